// File: doc/BRIEF.md
# Split Data/Address Register File with Condition Flags

This block holds the working registers of a processor datapath. It has sixteen 32-bit registers in two banks of eight. The data bank holds operands. The address bank holds pointers. The block also holds a four-bit condition-flag register. Two combinational read ports can reach any register in either bank, and one synchronous write port stores a result at the clock edge.

The destination bank decides how a write behaves. A data-bank write may be byte, word or longword. A narrow data write merges into the low bits and keeps the rest. When the flag enable is set, a data-bank write also loads the flags supplied by the ALU. An address-bank write with a narrow size stores the sign-extended low half-word. It never touches the flags, so pointer updates can sit in the middle of a data calculation without disturbing the flags that calculation relies on.

The write port carries a single-cycle strobe, `wr_valid`. The block accepts a write on every cycle, so there is no ready signal and no back-pressure. A source that presents a write must assume it is stored at the next rising edge.

Top module: `split_regfile`

## Requirements
- R1: While `rst_n` is low, every register in both banks reads 0 and `flags_out` is 0.
- R2: Each read port returns, in the same cycle, the register selected by its bank bit (0 = data bank, 1 = address bank) and its 3-bit index. The two ports are independent.
- R3: A write to the data bank with size 2'b10 (longword) stores all 32 bits. Size 2'b11 is also treated as longword.
- R4: When `wr_valid` and `wr_flag_en` are both high and the destination is the data bank, `flags_out` takes `flag_in` at the next rising edge. The flag bit order is bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.
- R5: A write to the address bank leaves `flags_out` unchanged, even when `wr_flag_en` is high.
- R6: A data-bank write of size 2'b00 (byte) replaces only bits 7:0. A write of size 2'b01 (word) replaces only bits 15:0. The upper bits keep their old value.
- R7: An address-bank write of size byte or word stores bits 15:0 of `wr_data` sign-extended to 32 bits. A longword write to the address bank stores all 32 bits.
- R8: A read of the register being written in the same cycle returns the old value. The new value becomes visible after the rising edge.
- R9: A write changes only the addressed register. The register with the same index in the other bank keeps its value.
- R10: With `wr_valid` low, no register and no flag changes, whatever `wr_flag_en` and the other write inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset that clears all state |
| rd0_bank | input | 1 | Read port 0 bank select (0 data, 1 address) |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_data | output | 32 | Read port 0 value |
| rd1_bank | input | 1 | Read port 1 bank select |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_data | output | 32 | Read port 1 value |
| wr_valid | input | 1 | Write strobe, accepted every cycle |
| wr_bank | input | 1 | Destination bank (0 data, 1 address) |
| wr_idx | input | 3 | Destination index |
| wr_size | input | 2 | 00 byte, 01 word, 10/11 longword |
| wr_data | input | 32 | Result value |
| wr_flag_en | input | 1 | Request to load flags from `flag_in` |
| flag_in | input | 4 | ALU flags {N,Z,V,C} |
| flags_out | output | 4 | Held flags {N,Z,V,C} |

## Verification
The bench sends an address-bank write with the flag enable high. A design that gated the flags on the enable alone would let the new flags through. It sends byte and word writes to a data register that already holds a full value. A design that zero-filled instead of merging would lose the upper bits. Word and byte writes to the address bank with bit 15 set and with bit 15 clear expose a design that skips sign extension, or that extends from bit 7. Further checks cover these cases:
- A read of the destination register in the write cycle, which catches a design that forwards the new value.
- The same index in the other bank, which catches a design that decodes the bank bit wrongly.
- A flag-enabled write with `wr_valid` low, which catches a design that ignores the strobe.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int IDX_W  = 3;
  localparam int FLAG_W = 4;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_WORD     = 2'd1,
    SZ_LONG     = 2'd2,
    SZ_LONG_ALT = 2'd3
  } size_e;

  typedef enum logic {
    BANK_DATA = 1'b0,
    BANK_ADDR = 1'b1
  } bank_e;
endpackage

// File: rtl/rf_merge.sv
module rf_merge
  import rf_pkg::*;
#(
  parameter int DW      = DATA_W,
  parameter bit IS_ADDR = 1'b0
) (
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] new_val,
  input  logic [1:0]    size,
  output logic [DW-1:0] merged
);
  localparam int BW = BYTE_W;
  localparam int WW = WORD_W;

  generate
    if (IS_ADDR) begin : g_addr
      // narrow pointer writes are widened from the low half-word
      always_comb begin
        if (size == SZ_BYTE || size == SZ_WORD)
          merged = {{(DW-WW){new_val[WW-1]}}, new_val[WW-1:0]};
        else
          merged = new_val;
      end
      logic unused_old;
      assign unused_old = ^old_val;
    end else begin : g_data
      always_comb begin
        case (size)
          SZ_BYTE: merged = {old_val[DW-1:BW], new_val[BW-1:0]};
          SZ_WORD: merged = {old_val[DW-1:WW], new_val[WW-1:0]};
          default: merged = new_val;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int DW      = DATA_W,
  parameter int IW      = IDX_W,
  parameter bit IS_ADDR = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_size,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data
);
  localparam int NREG = 1 << IW;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] merged;

  rf_merge #(.DW(DW), .IS_ADDR(IS_ADDR)) merge_i (
    .old_val (regs[wr_idx]),
    .new_val (wr_data),
    .size    (wr_size),
    .merged  (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_idx] <= merged;
    end
  end

  // reads see the state before the edge (R8)
  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

  generate
    if (IS_ADDR) begin : g_chk_addr
      p_addr_word_sext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_WORD) |=>
          regs[$past(wr_idx)] == {{(DW-WORD_W){$past(wr_data[WORD_W-1])}},
                                  $past(wr_data[WORD_W-1:0])});
    end else begin : g_chk_data
      p_byte_keeps_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_BYTE) |=>
          regs[$past(wr_idx)][DW-1:BYTE_W] == $past(regs[wr_idx][DW-1:BYTE_W]));
    end
  endgenerate
endmodule

// File: rtl/rf_ccr.sv
module rf_ccr
  import rf_pkg::*;
#(
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] d,
  output logic [FW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/split_regfile.sv
module split_regfile
  import rf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W,
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd0_bank,
  input  logic [IW-1:0] rd0_idx,
  output logic [DW-1:0] rd0_data,
  input  logic          rd1_bank,
  input  logic [IW-1:0] rd1_idx,
  output logic [DW-1:0] rd1_data,
  input  logic          wr_valid,
  input  logic          wr_bank,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_size,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_flag_en,
  input  logic [FW-1:0] flag_in,
  output logic [FW-1:0] flags_out
);
  localparam int NBANK = 2;

  logic [NBANK-1:0] bank_we;
  logic [DW-1:0]    ra_q [NBANK];
  logic [DW-1:0]    rb_q [NBANK];
  logic             flag_load;

  always_comb begin
    bank_we = '0;
    bank_we[wr_bank] = wr_valid;
  end

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      rf_bank #(.DW(DW), .IW(IW), .IS_ADDR(b == 1)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_we[b]),
        .wr_idx  (wr_idx),
        .wr_size (wr_size),
        .wr_data (wr_data),
        .ra_idx  (rd0_idx),
        .ra_data (ra_q[b]),
        .rb_idx  (rd1_idx),
        .rb_data (rb_q[b])
      );
    end
  endgenerate

  assign rd0_data = ra_q[rd0_bank];
  assign rd1_data = rb_q[rd1_bank];

  // only data-bank results may move the flags
  assign flag_load = wr_valid && wr_flag_en && (wr_bank == BANK_DATA);

  rf_ccr #(.FW(FW)) ccr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (flag_load),
    .d     (flag_in),
    .q     (flags_out)
  );

  p_flags_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_flag_en && wr_bank == BANK_DATA) |=> flags_out == $past(flag_in));

  p_addr_keeps_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_bank == BANK_ADDR) |=> $stable(flags_out));

  p_idle_keeps_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid) |=> $stable(flags_out));
endmodule

// File: tb/split_regfile_tb.sv
module split_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd0_bank = 1'b0, rd1_bank = 1'b0;
  logic [2:0]  rd0_idx = '0, rd1_idx = '0;
  logic [31:0] rd0_data, rd1_data;
  logic        wr_valid = 1'b0, wr_bank = 1'b0, wr_flag_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  flag_in = '0;
  logic [3:0]  flags_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  split_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd0_bank(rd0_bank), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_bank(rd1_bank), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .wr_size(wr_size), .wr_data(wr_data), .wr_flag_en(wr_flag_en),
    .flag_in(flag_in), .flags_out(flags_out)
  );

  // {bank, idx, size, data, flag_en, flag_in, expected value, expected flags}
  localparam int NV = 8;
  localparam logic [78:0] VEC [NV] = '{
    {1'b0, 3'd1, 2'd2, 32'h12345678, 1'b1, 4'h8, 32'h12345678, 4'h8}, // R3 R4
    {1'b0, 3'd1, 2'd0, 32'hAABBCCEF, 1'b1, 4'h4, 32'h123456EF, 4'h4}, // R6 byte
    {1'b0, 3'd1, 2'd1, 32'h0000BEEF, 1'b0, 4'hF, 32'h1234BEEF, 4'h4}, // R6 word
    {1'b1, 3'd2, 2'd1, 32'h00008001, 1'b1, 4'hF, 32'hFFFF8001, 4'h4}, // R5 R7
    {1'b1, 3'd2, 2'd0, 32'h12347F00, 1'b1, 4'h1, 32'h00007F00, 4'h4}, // R5 R7
    {1'b1, 3'd3, 2'd2, 32'hCAFEF00D, 1'b1, 4'h2, 32'hCAFEF00D, 4'h4}, // R7 long
    {1'b0, 3'd3, 2'd2, 32'h00000000, 1'b1, 4'h6, 32'h00000000, 4'h6}, // R4
    {1'b0, 3'd1, 2'd3, 32'h87654321, 1'b1, 4'h1, 32'h87654321, 4'h1}  // R3 size 11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic bank, input logic [2:0] idx, input logic [1:0] sz,
                          input logic [31:0] d, input logic fen, input logic [3:0] fl);
    @(negedge clk);
    wr_valid = 1'b1; wr_bank = bank; wr_idx = idx; wr_size = sz;
    wr_data = d; wr_flag_en = fen; flag_in = fl;
    @(negedge clk);
    wr_valid = 1'b0; wr_flag_en = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #23;
    rd0_bank = 1'b0; rd0_idx = 3'd5; rd1_bank = 1'b1; rd1_idx = 3'd7;
    #1;
    check("R1 data reg in reset", rd0_data, 32'h0);
    check("R1 addr reg in reset", rd1_data, 32'h0);
    check("R1 flags in reset", {28'h0, flags_out}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][78], VEC[i][77:75], VEC[i][74:73], VEC[i][72:41],
               VEC[i][40], VEC[i][39:36]);
      rd0_bank = VEC[i][78]; rd0_idx = VEC[i][77:75];
      #1;
      check($sformatf("R3/R6/R7 vector %0d value", i), rd0_data, VEC[i][35:4]);
      check($sformatf("R4/R5 vector %0d flags", i), {28'h0, flags_out}, {28'h0, VEC[i][3:0]});
    end

    // R2 and R9: both ports, same index in both banks
    rd0_bank = 1'b0; rd0_idx = 3'd3; rd1_bank = 1'b1; rd1_idx = 3'd3;
    #1;
    check("R9 D3 holds its own value", rd0_data, 32'h0);
    check("R9 A3 untouched by D3 write", rd1_data, 32'hCAFEF00D);
    rd0_bank = 1'b1; rd0_idx = 3'd2; rd1_bank = 1'b0; rd1_idx = 3'd1;
    #1;
    check("R2 port0 reads A2", rd0_data, 32'h00007F00);
    check("R2 port1 reads D1", rd1_data, 32'h87654321);

    // R8: read during write returns old value
    @(negedge clk);
    wr_valid = 1'b1; wr_bank = 1'b0; wr_idx = 3'd2; wr_size = 2'd2;
    wr_data = 32'h00000055; wr_flag_en = 1'b0;
    rd0_bank = 1'b0; rd0_idx = 3'd2;
    #1;
    check("R8 old value during write", rd0_data, 32'h0);
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
    check("R8 new value after edge", rd0_data, 32'h00000055);

    // R10: strobe low, flag enable high, nothing changes
    @(negedge clk);
    wr_valid = 1'b0; wr_bank = 1'b0; wr_idx = 3'd1; wr_size = 2'd2;
    wr_data = 32'hDEADBEEF; wr_flag_en = 1'b1; flag_in = 4'hE;
    @(negedge clk);
    @(negedge clk);
    wr_flag_en = 1'b0;
    rd0_bank = 1'b0; rd0_idx = 3'd1;
    #1;
    check("R10 D1 unchanged with strobe low", rd0_data, 32'h87654321);
    check("R10 flags unchanged with strobe low", {28'h0, flags_out}, 32'h1);

    // R1: reset during operation clears state
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 D1 cleared by reset", rd0_data, 32'h0);
    check("R1 flags cleared by reset", {28'h0, flags_out}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule